// File: doc/BRIEF.md
# Four-Phase Operand Sequencer

This block steps a small processor through its instructions. Operands and program words share one single-port register RAM of 2^AW words, DW bits wide. That RAM sits outside the block and has a combinational read port and a write port that captures on the clock edge. Each instruction takes four clocks, so one instruction completes every four cycles. In turn, the sequencer reads the source operand, reads the destination operand, fetches the following instruction word ahead of time, and then writes the result back while it steps the program counter.

After reset the block is idle. A start pulse supplies the first instruction word and sets the program counter to zero. From then on the sequencer runs without pause, taking each next instruction from the word it prefetched. The operands and the current instruction are held in registers and fed to a combinational ALU. The ALU has the whole fetch phase and the write-back phase to settle before its result is written.

Top module: `quad_phase_seq`

## Requirements
- R1: While rst_n is low and after reset until a start, busy_o is 0, ram_we is 0, phase_o is 0 and pc_o is 0.
- R2: start while idle loads start_instr as the current instruction and sets pc_o to 0. phase_o is 0 in the next cycle. start while busy has no effect on the sequence.
- R3: While busy, phase_o steps 0,1,2,3 and then returns to 0. Each instruction takes exactly four cycles.
- R4: ram_addr is set by the phase. In phase 0 it is the S field [AW-1:0]. In phase 1 it is the D field [2*AW-1:AW]. In phase 2 it is pc_o+1, modulo 2^AW. In phase 3 it is the D field again.
- R5: The result depends on the opcode in bits [31:26]. 0 gives src. 1 gives dst+src. 2 gives dst-src. 3 gives dst&src. 4 gives dst|src. 5 gives dst^src. Any other opcode gives dst unchanged.
- R6: When bit 22 of the instruction is set, src is the S field zero-extended, and the word read in phase 0 is ignored.
- R7: ram_we in phase 3 equals bit 25 of the instruction. With bit 25 clear, no write occurs, but pc_o still advances.
- R8: pc_o increments by one at the end of phase 3 and wraps from 2^AW-1 to 0. It is stable in all other phases.
- R9: ram_we is asserted only in phase 3. ram_wdata carries the ALU result at that time.
- R10: The next instruction is fetched in phase 2, before the write-back. When the current instruction writes to pc+1, the instruction executed next is the word held there before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, holds the sequencer idle |
| start | input | 1 | Begin sequencing with start_instr (used only while idle) |
| start_instr | input | DW | First instruction word |
| ram_rdata | input | DW | Combinational read data from the register RAM |
| ram_addr | output | AW | RAM word address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | DW | RAM write data (ALU result) |
| busy_o | output | 1 | Sequencer running |
| phase_o | output | 2 | Current phase, 0 to 3 |
| pc_o | output | AW | Program counter of the current instruction |

## Verification
The hardest case to reach is an instruction that writes to the very word that was just prefetched as its successor. Here the stale copy must run, even though the RAM already holds the new value. Random programs hit this only about once in 512 instructions. The stimulus therefore seeds every sixteenth word with a D field equal to its own address plus one, and the directed start word writes an immediate to address 1. A long run of 1200 instructions carries the program counter through its wrap twice. Start pulses injected during the run show that start has no effect while busy.

// File: rtl/seq_pkg.sv
package seq_pkg;
   typedef enum logic [1:0] {
      PH_SRC   = 2'd0,
      PH_DST   = 2'd1,
      PH_FETCH = 2'd2,
      PH_WB    = 2'd3
   } phase_t;

   localparam int OP_LSB  = 26;
   localparam int OP_W    = 6;
   localparam int WR_BIT  = 25;
   localparam int IMM_BIT = 22;

   localparam logic [OP_W-1:0] OP_MOV = 6'd0;
   localparam logic [OP_W-1:0] OP_ADD = 6'd1;
   localparam logic [OP_W-1:0] OP_SUB = 6'd2;
   localparam logic [OP_W-1:0] OP_AND = 6'd3;
   localparam logic [OP_W-1:0] OP_OR  = 6'd4;
   localparam logic [OP_W-1:0] OP_XOR = 6'd5;
endpackage

// File: rtl/seq_alu.sv
module seq_alu
   import seq_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [OP_W-1:0] op,
   input  logic [DW-1:0]   src,
   input  logic [DW-1:0]   dst,
   output logic [DW-1:0]   res
);
   always_comb begin
      case (op)
         OP_MOV:  res = src;
         OP_ADD:  res = dst + src;
         OP_SUB:  res = dst - src;
         OP_AND:  res = dst & src;
         OP_OR:   res = dst | src;
         OP_XOR:  res = dst ^ src;
         default: res = dst;
      endcase
   end
endmodule

// File: rtl/seq_phase_ctr.sv
module seq_phase_ctr (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   output logic       busy_o,
   output logic [1:0] phase_o
);
   logic       busy_q;
   logic [1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ph_q   <= 2'd0;
      end else if (go) begin
         busy_q <= 1'b1;
         ph_q   <= 2'd0;
      end else if (busy_q) begin
         ph_q   <= ph_q + 2'd1;
      end
   end

   assign busy_o  = busy_q;
   assign phase_o = ph_q;
endmodule

// File: rtl/quad_phase_seq.sv
module quad_phase_seq
   import seq_pkg::*;
#(
   parameter int AW = 9,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] start_instr,
   input  logic [DW-1:0] ram_rdata,
   output logic [AW-1:0] ram_addr,
   output logic          ram_we,
   output logic [DW-1:0] ram_wdata,
   output logic          busy_o,
   output logic [1:0]    phase_o,
   output logic [AW-1:0] pc_o
);
   localparam int S_LSB = 0;
   localparam int D_LSB = AW;
   localparam int D_MSB = 2 * AW - 1;

   generate
      if (DW < 32) begin : g_bad_dw
         $error("quad_phase_seq: DW must be at least 32");
      end
      if (AW < 1 || D_MSB >= IMM_BIT - 1) begin : g_bad_aw
         $error("quad_phase_seq: AW must leave the D field below the immediate bit");
      end
   endgenerate

   logic [DW-1:0] instr_q, nxt_q, src_q, dst_q;
   logic [AW-1:0] pc_q, pc_inc;
   logic [AW-1:0] fld_s, fld_d;
   logic          go, busy;
   logic [1:0]    ph_raw;
   phase_t        ph;
   logic [DW-1:0] alu_res;

   assign go     = start & ~busy;
   assign ph     = phase_t'(ph_raw);
   assign fld_s  = instr_q[S_LSB +: AW];
   assign fld_d  = instr_q[D_LSB +: AW];
   assign pc_inc = pc_q + AW'(1);

   seq_phase_ctr u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go),
      .busy_o  (busy),
      .phase_o (ph_raw)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         instr_q <= '0;
         nxt_q   <= '0;
         src_q   <= '0;
         dst_q   <= '0;
         pc_q    <= '0;
      end else if (go) begin
         instr_q <= start_instr;
         pc_q    <= '0;
      end else if (busy) begin
         case (ph)
            PH_SRC:   src_q <= instr_q[IMM_BIT] ? DW'(fld_s) : ram_rdata;
            PH_DST:   dst_q <= ram_rdata;
            PH_FETCH: nxt_q <= ram_rdata;
            PH_WB: begin
               instr_q <= nxt_q;
               pc_q    <= pc_inc;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      ram_addr = '0;
      if (busy) begin
         case (ph)
            PH_SRC:   ram_addr = fld_s;
            PH_DST:   ram_addr = fld_d;
            PH_FETCH: ram_addr = pc_inc;
            PH_WB:    ram_addr = fld_d;
            default:  ram_addr = '0;
         endcase
      end
   end

   seq_alu #(.DW(DW)) u_alu (
      .op  (instr_q[OP_LSB +: OP_W]),
      .src (src_q),
      .dst (dst_q),
      .res (alu_res)
   );

   assign ram_we    = busy & (ph == PH_WB) & instr_q[WR_BIT];
   assign ram_wdata = alu_res;
   assign busy_o    = busy;
   assign phase_o   = ph_raw;
   assign pc_o      = pc_q;

   logic unused_hi;
   logic unused_rsvd;
   generate
      if (DW > 32) begin : g_wide
         assign unused_hi = ^instr_q[DW-1:32];
      end else begin : g_exact
         assign unused_hi = 1'b0;
      end
   endgenerate
   assign unused_rsvd = ^{instr_q[WR_BIT-1:IMM_BIT+1], instr_q[IMM_BIT-1:D_MSB+1], unused_hi};
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
   parameter int AW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic [1:0]    phase,
   input logic [AW-1:0] pc,
   input logic [AW-1:0] ram_addr,
   input logic          ram_we
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ram_we && phase == 2'd0));

   assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && phase != 2'd3) |=> (busy && phase == $past(phase) + 2'd1));

   assert_phase_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && phase == 2'd3) |=> (busy && phase == 2'd0));

   assert_fetch_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && phase == 2'd2) |-> ram_addr == AW'(pc + AW'(1)));

   assert_wb_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && phase == 2'd3) |-> ram_addr == $past(ram_addr, 2));

   assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && phase == 2'd3) |=> pc == AW'($past(pc) + AW'(1)));

   assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && phase != 2'd3) |=> $stable(pc));

   assert_we_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (busy && phase == 2'd3));
endmodule

bind quad_phase_seq seq_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy_o),
   .phase    (phase_o),
   .pc       (pc_o),
   .ram_addr (ram_addr),
   .ram_we   (ram_we)
);

// File: tb/sim_quad_phase_seq.sv
`timescale 1ns/1ps
module sim_quad_phase_seq;
   localparam int AW = 9;
   localparam int DW = 32;
   localparam int N  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [DW-1:0] start_instr = '0;
   logic [DW-1:0] ram_rdata;
   logic [AW-1:0] ram_addr;
   logic          ram_we;
   logic [DW-1:0] ram_wdata;
   logic          busy;
   logic [1:0]    phase;
   logic [AW-1:0] pc;

   logic [DW-1:0] mem  [N];
   logic [DW-1:0] gmem [N];

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   assign ram_rdata = mem[ram_addr];
   always_ff @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

   quad_phase_seq #(.AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_instr(start_instr),
      .ram_rdata(ram_rdata), .ram_addr(ram_addr), .ram_we(ram_we),
      .ram_wdata(ram_wdata), .busy_o(busy), .phase_o(phase), .pc_o(pc)
   );

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] ref_alu(input logic [5:0] op, input logic [DW-1:0] s, input logic [DW-1:0] d);
      case (op)
         6'd0: return s;
         6'd1: return d + s;
         6'd2: return d - s;
         6'd3: return d & s;
         6'd4: return d | s;
         6'd5: return d ^ s;
         default: return d;
      endcase
   endfunction

   function automatic logic [DW-1:0] mk(input logic [5:0] op, input bit wr, input bit imm,
                                        input logic [AW-1:0] d, input logic [AW-1:0] s);
      logic [DW-1:0] w = '0;
      w[31:26] = op;
      w[25]    = wr;
      w[22]    = imm;
      w[17:9]  = d;
      w[8:0]   = s;
      return w;
   endfunction

   task automatic fill();
      for (int i = 0; i < N; i++) begin
         logic [AW-1:0] d = (i % 16 == 5) ? AW'(i + 1) : AW'($urandom);
         logic [DW-1:0] w = mk(6'($urandom_range(0, 7)), ($urandom % 4) != 0,
                               ($urandom % 3) == 0, d, AW'($urandom));
         mem[i]  = w;
         gmem[i] = w;
      end
   endtask

   task automatic run(input int n_instr, input logic [DW-1:0] first);
      logic [DW-1:0] cur = first;
      logic [AW-1:0] gpc = '0;
      bit stale = 1'b0;
      @(negedge clk);
      start = 1'b1;
      start_instr = first;
      @(negedge clk);
      start = 1'b0;
      chk(busy && phase == 2'd0 && pc == '0, "R2", {busy, phase, pc}, {1'b1, 2'd0, 9'd0});
      for (int k = 0; k < n_instr; k++) begin
         logic [AW-1:0] s = cur[8:0];
         logic [AW-1:0] d = cur[17:9];
         logic [AW-1:0] np = AW'(gpc + AW'(1));
         logic [DW-1:0] srcv = cur[22] ? DW'(s) : gmem[s];
         logic [DW-1:0] dstv = gmem[d];
         logic [DW-1:0] nxt = gmem[np];
         logic [DW-1:0] res = ref_alu(cur[31:26], srcv, dstv);
         // phase 0
         chk(phase == 2'd0, "R3", DW'(phase), 0);
         chk(ram_addr == s, stale ? "R10" : "R4", DW'(ram_addr), DW'(s));
         chk(pc == gpc, (gpc == '0 && k > 0) ? "R8 wrap" : "R8", DW'(pc), DW'(gpc));
         @(negedge clk);
         // phase 1, optional start pulse that must be ignored
         chk(ram_addr == d && !ram_we, "R4", DW'(ram_addr), DW'(d));
         if (k % 7 == 3) begin
            start = 1'b1;
            start_instr = $urandom;
         end
         @(negedge clk);
         start = 1'b0;
         // phase 2
         chk(busy && phase == 2'd2, "R2", DW'(phase), 2);
         chk(ram_addr == np && !ram_we, "R4", DW'(ram_addr), DW'(np));
         @(negedge clk);
         // phase 3
         chk(phase == 2'd3 && ram_addr == d, "R4", DW'(ram_addr), DW'(d));
         chk(ram_we == cur[25], "R7", DW'(ram_we), DW'(cur[25]));
         if (cur[25])
            chk(ram_wdata == res, cur[22] ? "R6" : "R5", ram_wdata, res);
         chk(pc == gpc, "R8", DW'(pc), DW'(gpc));
         stale = cur[25] && (d == np) && (res != nxt);
         if (cur[25]) gmem[d] = res;
         cur = nxt;
         gpc = np;
         @(negedge clk);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog R3: actual=hung expected=done");
      summary();
   end

   initial begin
      void'($urandom(32'd7));
      fill();
      repeat (2) @(negedge clk);
      chk(!busy && !ram_we && phase == 2'd0 && pc == '0, "R1", {busy, ram_we, phase, pc}, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(!busy && !ram_we && pc == '0, "R1", {busy, ram_we, pc}, 0);
      end
      // directed: immediate move into the prefetched word (address 1)
      run(1200, mk(6'd0, 1'b1, 1'b1, 9'd1, 9'h1AB));
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(!busy && !ram_we && phase == 2'd0 && pc == '0, "R1", {busy, ram_we, phase, pc}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      fill();
      // directed: immediate add with write suppressed
      run(300, mk(6'd1, 1'b0, 1'b1, 9'd3, 9'h055));
      summary();
   end
endmodule